// File: doc/BRIEF.md
# Span copy raster engine

The engine accepts a span-copy command packet as a stream of 32-bit words on a valid/ready input. It reads the header and the span count, then collects one descriptor per span: a pixel length, a source row and a destination row. Once the whole packet is held on chip, it copies each span from the source row of the framebuffer to the destination row. The copy runs column by column through a single-port framebuffer port that has a one-cycle read latency.

While it copies, the engine keeps a dirty rectangle up to date for a display refresher. Every finished span marks the full screen width dirty and widens the dirty row window so that it covers that span's source and destination rows. The engine shows `busy` while copying and pulses `done` when the packet is finished. It holds `in_ready` low for the whole copy, so a following packet waits at the input.

Top module: `span_copy_engine`

## Requirements
- R1: Only a header word equal to 0x00000405 starts a packet. Any other word arriving while a header is expected is consumed and has no effect: no framebuffer write, no `busy`, no `done`.
- R2: The span count is bits 31:24 of the word after the header, and the other 24 bits of that word are ignored. The next three words are ignored whatever their value. Descriptors follow, three words per span, in the order length, source, destination.
- R3: Each descriptor field is used after a right shift by 3. A row number is the low 10 bits of the shifted value, so rows wrap modulo 1024.
- R4: A shifted length greater than 1280 is clamped to 1280 pixels.
- R5: For each column c from 0 to length-1, in ascending order, the pixel at address src*1280+c is written to address dst*1280+c. Spans run in packet order, so a later span reads pixels that an earlier span wrote. A span whose length is zero writes nothing.
- R6: No framebuffer write occurs until the last word of the packet has been accepted. Every write happens while `busy` is high.
- R7: Each pixel takes a read followed by a write. The read address is held with `fb_we` low, the write data is taken from `fb_rdata` one cycle after the read address was presented, and `fb_we` is never high on two consecutive cycles. Consecutive pixels of a span are written exactly 3 cycles apart.
- R8: After each span, including a span of length zero, `dirty_any` is 1, the dirty column range is 0 to 1279, and the dirty row window becomes the smallest window that holds its previous extent and both the source and destination rows.
- R9: `in_ready` is low whenever `busy` is high. Input words offered in that time are held and are not consumed.
- R10: `done` is high for exactly one cycle, in the first cycle after `busy` falls, once every span has been copied. A packet with a span count of zero produces `done` with no writes and leaves the dirty outputs unchanged.
- R11: Reset drives the outputs to these values: `in_ready` 1, `busy` 0, `done` 0, `fb_we` 0, `dirty_any` 0, `dirty_x_lo` 0, `dirty_x_hi` 0, `dirty_y_lo` 1023, `dirty_y_hi` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Packet word is offered |
| in_data | input | 32 | Packet word |
| in_ready | output | 1 | Engine accepts a word on this cycle |
| fb_addr | output | 21 | Framebuffer pixel address, row*1280+column |
| fb_we | output | 1 | Framebuffer write strobe |
| fb_wdata | output | PIX_W | Pixel written to the framebuffer |
| fb_rdata | input | PIX_W | Pixel read, valid one cycle after the address |
| busy | output | 1 | Spans are being copied |
| done | output | 1 | One-cycle pulse at the end of a packet |
| dirty_any | output | 1 | At least one span has completed since reset |
| dirty_x_lo | output | 11 | First dirty column |
| dirty_x_hi | output | 11 | Last dirty column |
| dirty_y_lo | output | 10 | First dirty row |
| dirty_y_hi | output | 10 | Last dirty row |

## Verification
The assertions assume that the source of the packet holds `in_valid` and `in_data` steady until a word is accepted. They also assume that the framebuffer returns the addressed pixel on `fb_rdata` one cycle after it samples `fb_addr` with `fb_we` low. The bench meets the first assumption by offering each word at a falling edge and holding it until `in_ready` was seen high across a rising edge. It meets the second with a registered sparse memory model that is seeded with an address-dependent pattern. Reset is held for several cycles, so every `$past` term sees reset values and never undefined state.

// File: rtl/span_copy_pkg.sv
package span_copy_pkg;
  localparam logic [31:0] HDR_SPAN_COPY = 32'h0000_0405;
  localparam int CNT_LSB     = 24;
  localparam int CNT_W       = 8;
  localparam int FIELD_SHIFT = 3;
  localparam int SKIP_WORDS  = 3;

  typedef enum logic [2:0] {
    P_HDR, P_CNT, P_SKIP, P_DESC, P_WAIT
  } parse_st_e;

  typedef enum logic [2:0] {
    C_IDLE, C_FETCH, C_LATCH, C_RD, C_WAIT, C_WR, C_UPD, C_DONE
  } copy_st_e;
endpackage

// File: rtl/scp_span_ram.sv
module scp_span_ram #(
  parameter int W     = 31,
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/scp_parser.sv
module scp_parser
  import span_copy_pkg::*;
#(
  parameter int SCR_W = 1280,
  parameter int COL_W = 11,
  parameter int ROW_W = 10,
  parameter int IDX_W = 8,
  parameter int SPAN_W = COL_W + 2*ROW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       in_data,
  output logic              in_ready,
  input  logic              copy_done,
  output logic              go,
  output logic [CNT_W-1:0]  span_cnt,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [SPAN_W-1:0] wr_span
);
  parse_st_e        st;
  logic [1:0]       skip_n;
  logic [1:0]       sub;
  logic [IDX_W-1:0] idx;
  logic [COL_W-1:0] len_hold;
  logic [ROW_W-1:0] src_hold;
  logic             acc;

  assign acc = in_valid && in_ready;

  function automatic logic [COL_W-1:0] clamp_len(input logic [31:0] w);
    logic [31:0] s;
    s = w >> FIELD_SHIFT;
    if (s > 32'(SCR_W)) return COL_W'(SCR_W);
    return s[COL_W-1:0];
  endfunction

  function automatic logic [ROW_W-1:0] row_of(input logic [31:0] w);
    return w[FIELD_SHIFT +: ROW_W];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= P_HDR;
      in_ready <= 1'b1;
      go       <= 1'b0;
      span_cnt <= '0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_span  <= '0;
      skip_n   <= '0;
      sub      <= '0;
      idx      <= '0;
      len_hold <= '0;
      src_hold <= '0;
    end else begin
      go    <= 1'b0;
      wr_en <= 1'b0;
      if (st == P_WAIT && copy_done) begin
        st       <= P_HDR;
        in_ready <= 1'b1;
      end
      if (acc) begin
        case (st)
          P_HDR: if (in_data == HDR_SPAN_COPY) st <= P_CNT;
          P_CNT: begin
            span_cnt <= in_data[CNT_LSB +: CNT_W];
            skip_n   <= '0;
            st       <= P_SKIP;
          end
          P_SKIP: begin
            if (skip_n == 2'(SKIP_WORDS - 1)) begin
              sub <= '0;
              idx <= '0;
              if (span_cnt == '0) begin
                st       <= P_WAIT;
                in_ready <= 1'b0;
                go       <= 1'b1;
              end else begin
                st <= P_DESC;
              end
            end else begin
              skip_n <= skip_n + 2'd1;
            end
          end
          P_DESC: begin
            case (sub)
              2'd0: begin len_hold <= clamp_len(in_data); sub <= 2'd1; end
              2'd1: begin src_hold <= row_of(in_data);    sub <= 2'd2; end
              default: begin
                wr_en   <= 1'b1;
                wr_idx  <= idx;
                wr_span <= {len_hold, src_hold, row_of(in_data)};
                sub     <= 2'd0;
                if (idx == IDX_W'(span_cnt - 8'd1)) begin
                  st       <= P_WAIT;
                  in_ready <= 1'b0;
                  go       <= 1'b1;
                end else begin
                  idx <= idx + IDX_W'(1);
                end
              end
            endcase
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/scp_copier.sv
module scp_copier
  import span_copy_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int SCR_W  = 1280,
  parameter int COL_W  = 11,
  parameter int ROW_W  = 10,
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 21,
  parameter int SPAN_W = COL_W + 2*ROW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [CNT_W-1:0]  span_cnt,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [SPAN_W-1:0] span_word,
  output logic [ADDR_W-1:0] fb_addr,
  output logic              fb_we,
  output logic [PIX_W-1:0]  fb_wdata,
  input  logic [PIX_W-1:0]  fb_rdata,
  output logic              busy,
  output logic              done,
  output logic              upd,
  output logic [ROW_W-1:0]  upd_src,
  output logic [ROW_W-1:0]  upd_dst
);
  copy_st_e          st;
  logic [CNT_W-1:0]  n;
  logic [IDX_W-1:0]  idx;
  logic [COL_W-1:0]  len;
  logic [COL_W-1:0]  col;
  logic [ROW_W-1:0]  src_row, dst_row;
  logic [ADDR_W-1:0] src_base, dst_base;
  logic [COL_W-1:0]  w_len;
  logic [ROW_W-1:0]  w_src, w_dst;

  assign rd_idx = idx;
  assign w_len  = span_word[SPAN_W-1 -: COL_W];
  assign w_src  = span_word[2*ROW_W-1 -: ROW_W];
  assign w_dst  = span_word[ROW_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= C_IDLE;
      n        <= '0;
      idx      <= '0;
      len      <= '0;
      col      <= '0;
      src_row  <= '0;
      dst_row  <= '0;
      src_base <= '0;
      dst_base <= '0;
      fb_addr  <= '0;
      fb_we    <= 1'b0;
      fb_wdata <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      upd      <= 1'b0;
      upd_src  <= '0;
      upd_dst  <= '0;
    end else begin
      done <= 1'b0;
      upd  <= 1'b0;
      case (st)
        C_IDLE: if (go) begin
          n    <= span_cnt;
          idx  <= '0;
          busy <= 1'b1;
          st   <= (span_cnt == '0) ? C_DONE : C_FETCH;
        end
        C_FETCH: st <= C_LATCH;
        C_LATCH: begin
          len      <= w_len;
          src_row  <= w_src;
          dst_row  <= w_dst;
          src_base <= ADDR_W'(w_src) * ADDR_W'(SCR_W);
          dst_base <= ADDR_W'(w_dst) * ADDR_W'(SCR_W);
          col      <= '0;
          st       <= (w_len == '0) ? C_UPD : C_RD;
        end
        C_RD: begin
          fb_addr <= src_base + ADDR_W'(col);
          fb_we   <= 1'b0;
          st      <= C_WAIT;
        end
        C_WAIT: st <= C_WR;
        C_WR: begin
          fb_addr  <= dst_base + ADDR_W'(col);
          fb_we    <= 1'b1;
          fb_wdata <= fb_rdata;
          col      <= col + COL_W'(1);
          st       <= (col == len - COL_W'(1)) ? C_UPD : C_RD;
        end
        C_UPD: begin
          fb_we   <= 1'b0;
          upd     <= 1'b1;
          upd_src <= src_row;
          upd_dst <= dst_row;
          if (idx == IDX_W'(n - 8'd1)) begin
            st <= C_DONE;
          end else begin
            idx <= idx + IDX_W'(1);
            st  <= C_FETCH;
          end
        end
        default: begin
          fb_we <= 1'b0;
          busy  <= 1'b0;
          done  <= 1'b1;
          st    <= C_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/scp_dirty.sv
module scp_dirty #(
  parameter int SCR_W = 1280,
  parameter int COL_W = 11,
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [ROW_W-1:0] src,
  input  logic [ROW_W-1:0] dst,
  output logic             dirty_any,
  output logic [COL_W-1:0] x_lo,
  output logic [COL_W-1:0] x_hi,
  output logic [ROW_W-1:0] y_lo,
  output logic [ROW_W-1:0] y_hi
);
  logic [ROW_W-1:0] span_lo, span_hi;

  assign span_lo = (src < dst) ? src : dst;
  assign span_hi = (src < dst) ? dst : src;

  always_ff @(posedge clk) begin
    if (rst) begin
      dirty_any <= 1'b0;
      x_lo      <= '0;
      x_hi      <= '0;
      y_lo      <= '1;
      y_hi      <= '0;
    end else if (upd) begin
      dirty_any <= 1'b1;
      x_lo      <= '0;
      x_hi      <= COL_W'(SCR_W - 1);
      if (span_lo < y_lo) y_lo <= span_lo;
      if (span_hi > y_hi) y_hi <= span_hi;
    end
  end
endmodule

// File: rtl/span_copy_engine.sv
module span_copy_engine
  import span_copy_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int SCR_W = 1280,
  parameter int SCR_H = 1024
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             in_valid,
  input  logic [31:0]                      in_data,
  output logic                             in_ready,
  output logic [$clog2(SCR_W*SCR_H)-1:0]   fb_addr,
  output logic                             fb_we,
  output logic [PIX_W-1:0]                 fb_wdata,
  input  logic [PIX_W-1:0]                 fb_rdata,
  output logic                             busy,
  output logic                             done,
  output logic                             dirty_any,
  output logic [$clog2(SCR_W+1)-1:0]       dirty_x_lo,
  output logic [$clog2(SCR_W+1)-1:0]       dirty_x_hi,
  output logic [$clog2(SCR_H)-1:0]         dirty_y_lo,
  output logic [$clog2(SCR_H)-1:0]         dirty_y_hi
);
  localparam int COL_W  = $clog2(SCR_W + 1);
  localparam int ROW_W  = $clog2(SCR_H);
  localparam int ADDR_W = $clog2(SCR_W * SCR_H);
  localparam int IDX_W  = CNT_W;
  localparam int DEPTH  = 2 ** IDX_W;
  localparam int SPAN_W = COL_W + 2*ROW_W;

  logic              go;
  logic [CNT_W-1:0]  span_cnt;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [SPAN_W-1:0] wr_span, rd_span;
  logic              upd;
  logic [ROW_W-1:0]  upd_src, upd_dst;

  scp_parser #(.SCR_W(SCR_W), .COL_W(COL_W), .ROW_W(ROW_W), .IDX_W(IDX_W)) u_parse (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .copy_done(done), .go(go), .span_cnt(span_cnt),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_span(wr_span)
  );

  scp_span_ram #(.W(SPAN_W), .DEPTH(DEPTH), .AW(IDX_W)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_idx), .wdata(wr_span),
    .raddr(rd_idx), .rdata(rd_span)
  );

  scp_copier #(.PIX_W(PIX_W), .SCR_W(SCR_W), .COL_W(COL_W), .ROW_W(ROW_W),
               .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_copy (
    .clk(clk), .rst(rst), .go(go), .span_cnt(span_cnt),
    .rd_idx(rd_idx), .span_word(rd_span),
    .fb_addr(fb_addr), .fb_we(fb_we), .fb_wdata(fb_wdata), .fb_rdata(fb_rdata),
    .busy(busy), .done(done), .upd(upd), .upd_src(upd_src), .upd_dst(upd_dst)
  );

  scp_dirty #(.SCR_W(SCR_W), .COL_W(COL_W), .ROW_W(ROW_W)) u_dirty (
    .clk(clk), .rst(rst), .upd(upd), .src(upd_src), .dst(upd_dst),
    .dirty_any(dirty_any), .x_lo(dirty_x_lo), .x_hi(dirty_x_hi),
    .y_lo(dirty_y_lo), .y_hi(dirty_y_hi)
  );
endmodule

// File: rtl/span_copy_engine_chk.sv
module span_copy_engine_chk #(
  parameter int PIX_W = 8,
  parameter int SCR_W = 1280,
  parameter int SCR_H = 1024
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           in_ready,
  input logic                           fb_we,
  input logic                           busy,
  input logic                           done,
  input logic                           dirty_any,
  input logic [$clog2(SCR_W+1)-1:0]     dirty_x_lo,
  input logic [$clog2(SCR_W+1)-1:0]     dirty_x_hi,
  input logic [$clog2(SCR_H)-1:0]       dirty_y_lo,
  input logic [$clog2(SCR_H)-1:0]       dirty_y_hi
);
  // R9: no word is taken while spans are copied
  a_r9_ready_low_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !in_ready);

  // R6: writes only once the packet is complete
  a_r6_write_in_busy: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> busy);

  // R7: a write is always preceded by a read cycle
  a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    fb_we |=> !fb_we);

  // R10: done is a single-cycle pulse after busy falls
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R8: dirty columns cover the full width once set
  a_r8_full_width: assert property (@(posedge clk) disable iff (rst)
    dirty_any |-> (dirty_x_lo == '0 && 32'(dirty_x_hi) == SCR_W - 1));
  a_r8_window_ordered: assert property (@(posedge clk) disable iff (rst)
    dirty_any |-> (dirty_y_lo <= dirty_y_hi));
  a_r8_window_grows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (dirty_y_lo <= $past(dirty_y_lo) && dirty_y_hi >= $past(dirty_y_hi)));
endmodule

bind span_copy_engine span_copy_engine_chk #(.PIX_W(PIX_W), .SCR_W(SCR_W), .SCR_H(SCR_H)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .fb_we(fb_we), .busy(busy), .done(done),
  .dirty_any(dirty_any), .dirty_x_lo(dirty_x_lo), .dirty_x_hi(dirty_x_hi),
  .dirty_y_lo(dirty_y_lo), .dirty_y_hi(dirty_y_hi)
);

// File: tb/span_copy_engine_test.sv
module span_copy_engine_test;
  localparam int PIX_W = 8;
  localparam int SCR_W = 1280;
  localparam int SCR_H = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic [20:0] fb_addr;
  logic        fb_we;
  logic [PIX_W-1:0] fb_wdata, fb_rdata;
  logic        busy, done, dirty_any;
  logic [10:0] dirty_x_lo, dirty_x_hi;
  logic [9:0]  dirty_y_lo, dirty_y_hi;

  int total = 0;
  int bad = 0;

  span_copy_engine #(.PIX_W(PIX_W), .SCR_W(SCR_W), .SCR_H(SCR_H)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .fb_addr(fb_addr), .fb_we(fb_we), .fb_wdata(fb_wdata), .fb_rdata(fb_rdata),
    .busy(busy), .done(done), .dirty_any(dirty_any),
    .dirty_x_lo(dirty_x_lo), .dirty_x_hi(dirty_x_hi),
    .dirty_y_lo(dirty_y_lo), .dirty_y_hi(dirty_y_hi)
  );

  always #10 clk = ~clk;

  // framebuffer model: sparse, seeded, registered read
  logic [PIX_W-1:0] mem  [int];
  logic [PIX_W-1:0] shad [int];

  function automatic logic [PIX_W-1:0] seed(input int a);
    return PIX_W'(a * 37 + (a >>> 7) + 5);
  endfunction

  always @(posedge clk) begin
    logic [PIX_W-1:0] t;
    t = mem.exists(int'(fb_addr)) ? mem[int'(fb_addr)] : seed(int'(fb_addr));
    if (fb_we) mem[int'(fb_addr)] = fb_wdata;
    fb_rdata <= t;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard
  int               exp_addr_q[$];
  logic [PIX_W-1:0] exp_dat_q[$];
  int ex_any = 0, ex_ylo = 1023, ex_yhi = 0;
  int done_cnt = 0, viol_ready = 0;
  bit prev_done = 0, prev_we = 0;
  int cyc = 0, last_wr = -1, gap_min = 1000000, gap_max = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (busy && in_ready) viol_ready++;
      if (done) begin
        done_cnt++;
        chk(!prev_done && !busy, "R10", "done single and busy low", int'(prev_done), 0);
      end
      if (fb_we) begin
        chk(busy, "R6", "write outside busy", int'(busy), 1);
        chk(!prev_we, "R7", "back-to-back write", int'(prev_we), 0);
        if (last_wr >= 0) begin
          if (cyc - last_wr < gap_min) gap_min = cyc - last_wr;
          if (cyc - last_wr > gap_max) gap_max = cyc - last_wr;
        end
        last_wr = cyc;
        if (exp_addr_q.size() == 0) begin
          chk(0, "R5", "unexpected write addr", int'(fb_addr), -1);
        end else begin
          int ea;
          logic [PIX_W-1:0] ed;
          ea = exp_addr_q.pop_front();
          ed = exp_dat_q.pop_front();
          chk(int'(fb_addr) == ea, "R5", "write address", int'(fb_addr), ea);
          chk(fb_wdata == ed, "R5", "write data", int'(fb_wdata), int'(ed));
        end
      end
      prev_done = done;
      prev_we = fb_we;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // driver
  int unsigned desc[$];
  int nsp = 0;

  function automatic logic [PIX_W-1:0] sh_rd(input int a);
    return shad.exists(a) ? shad[a] : seed(a);
  endfunction

  task automatic begin_pkt();
    desc.delete();
    nsp = 0;
  endtask

  task automatic add_span(input int unsigned lw, input int unsigned sw, input int unsigned dw);
    int len, s, d;
    len = int'(lw >> 3);
    if (len > SCR_W) len = SCR_W;
    s = int'((sw >> 3) & 32'd1023);
    d = int'((dw >> 3) & 32'd1023);
    for (int c = 0; c < len; c++) begin
      logic [PIX_W-1:0] v;
      v = sh_rd(s * SCR_W + c);
      exp_addr_q.push_back(d * SCR_W + c);
      exp_dat_q.push_back(v);
      shad[d * SCR_W + c] = v;
    end
    ex_any = 1;
    if (s < ex_ylo) ex_ylo = s;
    if (d < ex_ylo) ex_ylo = d;
    if (s > ex_yhi) ex_yhi = s;
    if (d > ex_yhi) ex_yhi = d;
    desc.push_back(lw); desc.push_back(sw); desc.push_back(dw);
    nsp++;
  endtask

  task automatic send_word(input logic [31:0] w);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_pkt();
    send_word(32'h405);
    send_word((32'(nsp) << 24) | 32'h00AB_CD17);
    send_word(32'h405);
    send_word(32'hFFFF_FFFF);
    send_word(32'h0000_0123);
    foreach (desc[i]) send_word(desc[i]);
    in_valid = 1'b0;
  endtask

  task automatic wait_done(input int target);
    int t = 0;
    while (done_cnt < target && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(done_cnt >= target, "R10", "done seen", done_cnt, target);
  endtask

  task automatic check_dirty(input string tag);
    chk(int'(dirty_any) == ex_any, "R8", {tag, " dirty_any"}, int'(dirty_any), ex_any);
    chk(int'(dirty_y_lo) == ex_ylo, "R8", {tag, " y_lo"}, int'(dirty_y_lo), ex_ylo);
    chk(int'(dirty_y_hi) == ex_yhi, "R8", {tag, " y_hi"}, int'(dirty_y_hi), ex_yhi);
    if (ex_any != 0) begin
      chk(dirty_x_lo == 0, "R8", {tag, " x_lo"}, int'(dirty_x_lo), 0);
      chk(int'(dirty_x_hi) == SCR_W - 1, "R8", {tag, " x_hi"}, int'(dirty_x_hi), SCR_W - 1);
    end
  endtask

  initial begin
    int dc;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk(in_ready == 1'b1, "R11", "in_ready", int'(in_ready), 1);
    chk(busy == 1'b0 && done == 1'b0, "R11", "busy/done", int'(busy) + int'(done), 0);
    chk(fb_we == 1'b0, "R11", "fb_we", int'(fb_we), 0);
    chk(dirty_any == 1'b0 && dirty_x_lo == 0 && dirty_x_hi == 0, "R11", "dirty x",
        int'(dirty_x_hi), 0);
    chk(dirty_y_lo == 10'd1023 && dirty_y_hi == 0, "R11", "dirty y", int'(dirty_y_lo), 1023);

    // R2 R5 R8: single span, 4 pixels, row 10 -> row 20
    begin_pkt();
    add_span(32, 80, 160);
    send_pkt();
    wait_done(1);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done dropped", int'(done), 0);
    chk(exp_addr_q.size() == 0, "R5", "pending writes single", exp_addr_q.size(), 0);
    check_dirty("single");

    // R1: stray words while a header is expected
    dc = done_cnt;
    send_word(32'h404);
    send_word(32'h0000_0406);
    in_valid = 1'b0;
    repeat (12) @(negedge clk);
    chk(done_cnt == dc && busy == 1'b0, "R1", "stray header effect", done_cnt, dc);
    chk(in_ready == 1'b1, "R1", "ready after stray", int'(in_ready), 1);

    // R3 R5 R8: ordering, zero length, low bits, row wrap
    begin_pkt();
    add_span(47, 29, 5600);
    add_span(7, 7200, 16);
    add_span(24, 5600, 8592);
    send_pkt();
    wait_done(2);
    chk(exp_addr_q.size() == 0, "R3", "pending writes multi", exp_addr_q.size(), 0);
    check_dirty("multi");

    // R4 R7: clamp to full width, pacing of writes
    gap_min = 1000000; gap_max = 0; last_wr = -1;
    begin_pkt();
    add_span(32'h0010_0000, 800, 808);
    send_pkt();
    wait_done(3);
    chk(exp_addr_q.size() == 0, "R4", "clamped span writes", exp_addr_q.size(), 0);
    chk(gap_min == 3 && gap_max == 3, "R7", "pixel spacing", gap_max, 3);
    check_dirty("clamp");

    // R10: zero spans
    begin_pkt();
    send_pkt();
    wait_done(4);
    chk(exp_addr_q.size() == 0, "R10", "zero-span writes", exp_addr_q.size(), 0);
    check_dirty("zero");

    // R9: back-to-back packets, second held at input
    begin_pkt();
    add_span(80, 400, 8000);
    add_span(16, 8000, 1600);
    send_pkt();
    begin_pkt();
    add_span(40, 1600, 2400);
    send_pkt();
    wait_done(6);
    chk(viol_ready == 0, "R9", "ready while busy", viol_ready, 0);
    chk(exp_addr_q.size() == 0, "R9", "pending writes b2b", exp_addr_q.size(), 0);
    check_dirty("b2b");

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule